// File: doc/BRIEF.md
# Programmable I/O Output Function Generator

This block produces the value driven toward a pad by a programmable I/O cell. Each lane has two data inputs, `out1` and `out2`, and an output flip-flop that samples `out1`. A static mode code chooses one of nine ways to form the pad value. Three modes are clock-phase multiplexers: they pass one source while the clock operand is low and a second source while it is high. The other six modes are two-input gates whose operands are `out2` and the clock operand.

The clock acts as a clock for the output flip-flop, and it also acts as data and as a select line. Because of this, the pad value can change in the middle of a cycle and not only at clock edges. A static bit can invert the clock operand before it is used, and that bit applies to all nine modes. The flip-flop always samples on the rising edge of the real clock. The output-enable path is a plain pass-through. All lanes share the mode and the inversion bit.

Top module: `pio_out_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the output flip-flop of every lane is cleared to 0. With mode code 9, `pad_o` then reads 0.
- R2: At a rising clock edge with `rst` low, each lane's flip-flop loads `out1` when `ce` is 1. It keeps its value when `ce` is 0.
- R3: Mode code 0 drives `out1` while the clock operand is low and the flip-flop value while it is high.
- R4: Mode code 1 drives `out2` while the clock operand is low and the flip-flop value while it is high.
- R5: Mode code 2 drives `out1` while the clock operand is low and `out2` while it is high.
- R6: Mode codes 3 to 8 drive a gate of `out2` and the clock operand. The code-to-gate mapping is 3 AND, 4 NAND, 5 OR, 6 NOR, 7 XOR, 8 XNOR.
- R7: Mode codes 9 to 15 drive the flip-flop value in both clock phases.
- R8: The clock operand equals `clk` when `clk_inv` is 0 and the inverse of `clk` when `clk_inv` is 1, in every mode.
- R9: `pad_oe` equals `oe_in` lane by lane at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop, also used as a data operand |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| ce | input | 1 | Clock enable of the output flip-flops |
| clk_inv | input | 1 | Static: invert the clock operand |
| mode | input | 4 | Static output function code |
| out1 | input | LANES | First data input per lane |
| out2 | input | LANES | Second data input per lane |
| oe_in | input | LANES | Output enable per lane |
| pad_o | output | LANES | Pad output value per lane |
| pad_oe | output | LANES | Pad output enable per lane |

## Verification
The pad value is sampled once in the low phase and once in the high phase of every cycle, for all sixteen mode codes and both settings of the inversion bit. The `out1` and `out2` vectors are chosen so that the four lanes together cover all four combinations of the two data bits. This separates the three multiplexer modes from one another, since each passes a different source in a different phase. It also separates the six gates, since each has a distinct truth table over `out2` and the clock. Random sequences of `ce` and data make the flip-flop value differ from the combinational inputs. A mode that passes the wrong source, or a flip-flop that ignores its enable, therefore shows up as a mismatch.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Output function codes; the numbering is part of the block's interface
  typedef enum logic [3:0] {
    M_O1_REG = 4'd0,
    M_O2_REG = 4'd1,
    M_O1_O2  = 4'd2,
    M_AND    = 4'd3,
    M_NAND   = 4'd4,
    M_OR     = 4'd5,
    M_NOR    = 4'd6,
    M_XOR    = 4'd7,
    M_XNOR   = 4'd8
  } pio_mode_e;

  localparam int MODE_W    = 4;
  localparam int LAST_MODE = 8;

endpackage

// File: rtl/pio_out_reg.sv
module pio_out_reg #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ce)
      q <= d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> q == '0); // R1
  AST_CE_LOAD: assert property (@(posedge clk) disable iff (rst) ce |=> q == $past(d)); // R2
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(q)); // R2

endmodule

// File: rtl/pio_lane_sel.sv
module pio_lane_sel
  import pio_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              ck_op,
  input  logic [LANES-1:0]  o1,
  input  logic [LANES-1:0]  o2,
  input  logic [LANES-1:0]  q,
  output logic [LANES-1:0]  y
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (mode)
        M_O1_REG: y[g] = ck_op ? q[g]  : o1[g];
        M_O2_REG: y[g] = ck_op ? q[g]  : o2[g];
        M_O1_O2:  y[g] = ck_op ? o2[g] : o1[g];
        M_AND:    y[g] =   o2[g] & ck_op;
        M_NAND:   y[g] = ~(o2[g] & ck_op);
        M_OR:     y[g] =   o2[g] | ck_op;
        M_NOR:    y[g] = ~(o2[g] | ck_op);
        M_XOR:    y[g] =   o2[g] ^ ck_op;
        M_XNOR:   y[g] = ~(o2[g] ^ ck_op);
        default:  y[g] = q[g];
      endcase
      if (mode == M_O1_O2 && o1[g] == o2[g]) begin
        AST_MUX_AGREE: assert (y[g] == o1[g]); // R5
      end
      if (mode == M_AND && !o2[g]) begin
        AST_AND_LOW: assert (y[g] == 1'b0); // R6
      end
      if (mode == M_OR && o2[g]) begin
        AST_OR_HIGH: assert (y[g] == 1'b1); // R6
      end
    end
  end

endmodule

// File: rtl/pio_out_gen.sv
module pio_out_gen
  import pio_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              clk_inv,
  input  logic [MODE_W-1:0] mode,
  input  logic [LANES-1:0]  out1,
  input  logic [LANES-1:0]  out2,
  input  logic [LANES-1:0]  oe_in,
  output logic [LANES-1:0]  pad_o,
  output logic [LANES-1:0]  pad_oe
);

  logic             ck_op;
  logic [LANES-1:0] ff_q;

  // clock used as data operand, optionally inverted (R8)
  assign ck_op  = clk ^ clk_inv;
  assign pad_oe = oe_in;

  pio_out_reg #(.LANES(LANES)) i_reg (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (out1),
    .q   (ff_q)
  );

  pio_lane_sel #(.LANES(LANES)) i_sel (
    .mode  (mode),
    .ck_op (ck_op),
    .o1    (out1),
    .o2    (out2),
    .q     (ff_q),
    .y     (pad_o)
  );

endmodule

// File: tb/test_pio_out_gen.sv
module test_pio_out_gen;

  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic         clk_inv = 1'b0;
  logic [3:0]   mode = 4'd9;
  logic [L-1:0] out1 = '0, out2 = '0, oe_in = '0;
  logic [L-1:0] pad_o, pad_oe;

  logic [L-1:0] mq = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pio_out_gen #(.LANES(L)) i_pio_out_gen (
    .clk(clk), .rst(rst), .ce(ce), .clk_inv(clk_inv), .mode(mode),
    .out1(out1), .out2(out2), .oe_in(oe_in), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  function automatic logic [L-1:0] expect_pad(input logic [3:0] m, input logic k,
      input logic [L-1:0] a, input logic [L-1:0] b, input logic [L-1:0] q);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) begin
      case (m)
        4'd0: r[i] = k ? q[i] : a[i];
        4'd1: r[i] = k ? q[i] : b[i];
        4'd2: r[i] = k ? b[i] : a[i];
        4'd3: r[i] = b[i] & k;
        4'd4: r[i] = !(b[i] & k);
        4'd5: r[i] = b[i] | k;
        4'd6: r[i] = !(b[i] | k);
        4'd7: r[i] = b[i] ^ k;
        4'd8: r[i] = !(b[i] ^ k);
        default: r[i] = q[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] m, input logic inv);
    string t;
    if (m == 0) t = "R3";
    else if (m == 1) t = "R4";
    else if (m == 2) t = "R5";
    else if (m <= 8) t = "R6";
    else t = "R7";
    if (inv) t = {t, "+R8"};
    return t;
  endfunction

  task automatic check(input string tag, input logic [L-1:0] got, input logic [L-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic sample(input logic phase, input string tag);
    string t;
    t = (tag == "") ? tag_of(mode, clk_inv) : tag;
    check(t, pad_o, expect_pad(mode, phase ^ clk_inv, out1, out2, mq));
    check("R9", pad_oe, oe_in);
  endtask

  // one cycle: drive after falling edge, check low phase, then high phase
  task automatic step(input logic [3:0] m, input logic inv, input logic [L-1:0] a,
      input logic [L-1:0] b, input logic c, input logic r, input string tag);
    @(negedge clk);
    #1;
    mode = m; clk_inv = inv; out1 = a; out2 = b; ce = c; rst = r;
    oe_in = L'($urandom);
    #1;
    sample(1'b0, tag);
    @(posedge clk);
    if (r) mq = '0;
    else if (c) mq = a;
    #2;
    sample(1'b1, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    // R1: reset clears the flip-flop, visible through mode 9
    step(4'd9, 1'b0, '1, '1, 1'b1, 1'b1, "R1");
    check("R1", pad_o, '0);
    // R2: load then hold with ce low
    step(4'd9, 1'b0, 4'b1011, '0, 1'b1, 1'b0, "R2");
    step(4'd9, 1'b0, 4'b0100, '0, 1'b0, 1'b0, "R2");
    check("R2", pad_o, 4'b1011);
    // every mode, both inversion settings, all out1/out2 pairs across lanes
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 2; v++) begin
        step(4'(m), v[0], 4'b1010, 4'b1100, 1'b1, 1'b0, "");
        step(4'(m), v[0], 4'b0101, 4'b0011, 1'b0, 1'b0, "");
        step(4'(m), v[0], 4'b1010, 4'b1100, 1'b0, 1'b0, "");
      end
    end
    // random sequences per mode
    for (int n = 0; n < 400; n++) begin
      step(4'($urandom_range(0, 15)), 1'($urandom), L'($urandom), L'($urandom),
           1'($urandom), ($urandom_range(0, 19) == 0), "");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule